// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block receives asynchronous serial frames of 5 to 9 data bits, least significant bit first, with an optional even parity bit and one stop bit. It oversamples the line on a baud-tick enable, either 16 or 8 ticks per bit. It checks a start bit, decides each bit by a 2-of-3 majority vote around the bit centre, checks parity and the stop bit, and places the result in a one-deep receive buffer. Software empties the buffer with a read strobe.

A node on a shared multi-drop bus can set the filter input. While it is set, the receiver keeps only address frames. The frame-type bit is the ninth data bit in 9-bit frames and the stop bit in shorter frames. Once software sees its own address, it clears the filter input and receives the data frames that follow.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset `rxValid`, `rxOverrun`, `rxFrameErr`, `rxParityErr`, `rxBit9` and `rxData` are all 0.
- R2: `dataLen` codes 0,1,2,3,4 select 5,6,7,8,9 data bits, and codes above 4 act as 9. Bits arrive LSB first. Bits 0..7 appear right-aligned on `rxData`, and unused upper bits read 0.
- R3: A falling edge starts a frame only if the majority of the three samples around the start-bit centre is low. A shorter low pulse stores nothing.
- R4: Each bit is the 2-of-3 majority of the samples on ticks 7, 8 and 9 (16x) or 3, 4 and 5 (8x) of its bit period, so a one-sample glitch does not change it.
- R5: When `parityEn` is 1, a parity bit follows the data bits. `rxParityErr` is stored as 1 when data and parity bits together hold an odd number of ones.
- R6: `rxFrameErr` is stored as 1 for a stored frame whose stop bit samples as 0.
- R7: The frame-type bit is data bit 8 for 9-bit frames and the stop bit otherwise. It is stored on `rxBit9`, and 1 means address.
- R8: With `filterEn` = 1, a frame whose type bit is 0 is discarded. `rxValid`, the stored fields and `rxOverrun` are left unchanged.
- R9: With `filterEn` = 0, every frame that passes the start check is stored.
- R10: A frame to be stored that completes while `rxValid` is 1 is discarded, and `rxOverrun` is set. The earlier frame stays intact. `rxOverrun` clears on `rxRead`.
- R11: A one-cycle `rxRead` clears `rxValid`.
- R12: `doubleSpeed` = 1 selects 8 ticks per bit, and 0 selects 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input, idle high |
| sampleTick | input | 1 | One-cycle oversampling enable |
| doubleSpeed | input | 1 | 1: 8 ticks per bit, 0: 16 |
| dataLen | input | 3 | Data length code (0..4 = 5..9 bits) |
| parityEn | input | 1 | Expect an even parity bit |
| filterEn | input | 1 | Keep only address frames |
| rxRead | input | 1 | Read strobe, empties the buffer |
| rxValid | output | 1 | Buffer holds a frame |
| rxData | output | 8 | Data bits 0..7 |
| rxBit9 | output | 1 | Frame-type / ninth bit |
| rxFrameErr | output | 1 | Stored frame had a low stop bit |
| rxParityErr | output | 1 | Stored frame had a parity mismatch |
| rxOverrun | output | 1 | A frame was lost to a full buffer |

## Verification
A wrong slot or tick count in the sequencer shows up at the end of the same frame. The symptoms are a shifted data byte, a wrong ninth bit, a spurious frame error, or a frame that never arrives. A buffer-state error shows up on the next frame or the next read, as a lost overrun, a clobbered byte or a valid flag that stays set. Filter-decision faults appear as a data frame that lands in an empty buffer, or an address frame that is missing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_DATA = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rxState_e;

  typedef struct packed {
    logic clearAcc;
    logic shiftData;
    logic capParity;
    logic finish;
  } rxStrobe_t;

  function automatic logic [3:0] dataBits(input logic [2:0] code);
    return (code > 3'd4) ? 4'd9 : 4'(code) + 4'd5;
  endfunction

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR_NORMAL = 16,
  parameter int OSR_FAST = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineIn,
  input  logic       vote,
  input  logic       doubleSpeed,
  input  logic [2:0] dataLen,
  input  logic       parityEn,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(OSR_NORMAL);
  localparam int SLOT_W = $clog2(MAX_DATA + 3);

  rxState_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] nData, stopSlot;
  logic [CNT_W-1:0]  lastTick, decideAt;
  logic              decide;

  assign nData    = SLOT_W'(dataBits(dataLen));
  assign stopSlot = nData + SLOT_W'(parityEn);
  assign lastTick = doubleSpeed ? CNT_W'(OSR_FAST - 1) : CNT_W'(OSR_NORMAL - 1);
  assign decideAt = doubleSpeed ? CNT_W'(OSR_FAST / 2 + 1) : CNT_W'(OSR_NORMAL / 2 + 1);
  assign decide   = tick && (cnt == decideAt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      slot  <= '0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: if (!lineIn) begin
          state <= ST_START;
          cnt   <= CNT_W'(1);
        end
        ST_START: begin
          if (decide && vote) state <= ST_IDLE;
          else if (cnt == lastTick) begin
            state <= ST_BITS;
            cnt   <= '0;
            slot  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_BITS: begin
          if (decide && slot == stopSlot) state <= ST_IDLE;
          else if (cnt == lastTick) begin
            cnt  <= '0;
            slot <= slot + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearAcc  = tick && state == ST_IDLE && !lineIn;
    strb.shiftData = decide && state == ST_BITS && slot < nData;
    strb.capParity = decide && state == ST_BITS && parityEn && slot == nData;
    strb.finish    = decide && state == ST_BITS && slot == stopSlot;
  end

  // R2: at most one bit action per cycle
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clearAcc, strb.shiftData, strb.capParity, strb.finish}));

  // R3: a high start-centre vote returns to idle
  p_start_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && decide && vote) |=> (state == ST_IDLE));
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineIn,
  input  rxStrobe_t  strb,
  input  logic [2:0] dataLen,
  input  logic       parityEn,
  input  logic       filterEn,
  input  logic       rxRead,
  output logic       vote,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxFrameErr,
  output logic       rxParityErr,
  output logic       rxOverrun
);
  logic [1:0]          hist;
  logic [MAX_DATA-1:0] shiftReg, aligned;
  logic                parityAcc;
  logic [3:0]          nBits;
  logic                typeBit, storeReq, canWrite;

  assign vote     = majority3(hist[1], hist[0], lineIn);
  assign nBits    = dataBits(dataLen);
  assign aligned  = shiftReg >> (4'(MAX_DATA) - nBits);
  assign typeBit  = (nBits == 4'(MAX_DATA)) ? aligned[MAX_DATA-1] : vote;
  assign storeReq = strb.finish && !(filterEn && !typeBit);
  assign canWrite = !rxValid || rxRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist      <= 2'b11;
      shiftReg  <= '0;
      parityAcc <= 1'b0;
    end else begin
      if (tick) hist <= {hist[0], lineIn};
      if (strb.clearAcc) begin
        shiftReg  <= '0;
        parityAcc <= 1'b0;
      end else if (strb.shiftData) begin
        shiftReg  <= {vote, shiftReg[MAX_DATA-1:1]};
        parityAcc <= parityAcc ^ vote;
      end else if (strb.capParity) begin
        parityAcc <= parityAcc ^ vote;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid     <= 1'b0;
      rxData      <= '0;
      rxBit9      <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
      rxOverrun   <= 1'b0;
    end else begin
      if (rxRead) begin
        rxValid   <= 1'b0;
        rxOverrun <= 1'b0;
      end
      if (storeReq) begin
        if (canWrite) begin
          rxValid     <= 1'b1;
          rxData      <= aligned[7:0];
          rxBit9      <= typeBit;
          rxFrameErr  <= !vote;
          rxParityErr <= parityEn && parityAcc;
        end else begin
          rxOverrun <= 1'b1;
        end
      end
    end
  end

  // R11: a read with no completing frame empties the buffer
  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strb.finish) |=> !rxValid);

  // R10: a full buffer keeps its byte and flags overrun
  p_overrun_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxRead && storeReq) |=> (rxOverrun && $stable(rxData) && rxValid));

  // R8: a data frame under filtering leaves an empty buffer empty
  p_filter_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid && !rxRead && strb.finish && filterEn && !typeBit) |=> !rxValid);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR_NORMAL = 16,
  parameter int OSR_FAST = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       sampleTick,
  input  logic       doubleSpeed,
  input  logic [2:0] dataLen,
  input  logic       parityEn,
  input  logic       filterEn,
  input  logic       rxRead,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       rxFrameErr,
  output logic       rxParityErr,
  output logic       rxOverrun
);
  logic [1:0] syncLine;
  logic       vote;
  rxStrobe_t  strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncLine <= 2'b11;
    else       syncLine <= {syncLine[0], rxLine};
  end

  uart_rx_ctrl #(.OSR_NORMAL(OSR_NORMAL), .OSR_FAST(OSR_FAST)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .lineIn(syncLine[1]), .vote(vote),
    .doubleSpeed(doubleSpeed), .dataLen(dataLen), .parityEn(parityEn), .strb(strb)
  );

  uart_rx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .lineIn(syncLine[1]), .strb(strb),
    .dataLen(dataLen), .parityEn(parityEn), .filterEn(filterEn), .rxRead(rxRead),
    .vote(vote), .rxValid(rxValid), .rxData(rxData), .rxBit9(rxBit9),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxOverrun(rxOverrun)
  );
endmodule

// File: tb/uart_addr_rx_bench.sv
`timescale 1ns/1ps
module uart_addr_rx_bench;
  logic clk = 1'b0, rstN = 1'b0, rxLine = 1'b1, sampleTick = 1'b0;
  logic doubleSpeed = 1'b0, parityEn = 1'b0, filterEn = 1'b0, rxRead = 1'b0;
  logic [2:0] dataLen = 3'd3;
  logic rxValid, rxBit9, rxFrameErr, rxParityErr, rxOverrun;
  logic [7:0] rxData;
  int errors = 0, checks = 0;
  logic mValid = 0, mBit9 = 0, mFerr = 0, mPerr = 0, mOvr = 0;
  logic [7:0] mData = 0;

  always #2.5 clk = ~clk;

  uart_addr_rx u_uart_addr_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .doubleSpeed(doubleSpeed), .dataLen(dataLen), .parityEn(parityEn),
    .filterEn(filterEn), .rxRead(rxRead), .rxValid(rxValid), .rxData(rxData),
    .rxBit9(rxBit9), .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .rxOverrun(rxOverrun)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      sampleTick = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, {8'(rxValid), rxData}, {8'(mValid), mData});
    check(req, {12'd0, rxBit9, rxFrameErr, rxParityErr, rxOverrun},
          {12'd0, mBit9, mFerr, mPerr, mOvr});
  endtask

  task automatic holdBit(input logic v, input int clocks);
    rxLine = v;
    repeat (clocks) @(negedge clk);
  endtask

  function automatic logic [8:0] maskData(input int len, input logic [8:0] d);
    return d & 9'((1 << len) - 1);
  endfunction

  // drives one frame and updates the model; glitchBit>=0 flips one sample of that data bit
  task automatic sendFrame(input int len, input logic [8:0] d, input logic par,
                           input logic badPar, input logic stopVal, input logic dbl,
                           input int glitchBit);
    int bc;
    logic [8:0] md;
    logic typeBit;
    md = maskData(len, d);
    doubleSpeed = dbl; parityEn = par; dataLen = 3'(len - 5);
    bc = (dbl ? 8 : 16) * 4;
    while (sampleTick !== 1'b1) @(negedge clk);
    holdBit(1'b0, bc);
    for (int i = 0; i < len; i++) begin
      if (i == glitchBit) begin
        holdBit(md[i], 33);
        holdBit(!md[i], 4);
        holdBit(md[i], bc - 37);
      end else holdBit(md[i], bc);
    end
    if (par) holdBit((^md) ^ badPar, bc);
    holdBit(stopVal, bc);
    holdBit(1'b1, 2 * bc);
    typeBit = (len == 9) ? md[8] : stopVal;
    if (!(filterEn && !typeBit)) begin
      if (mValid) mOvr = 1;
      else begin
        mValid = 1; mData = md[7:0]; mBit9 = typeBit;
        mFerr = !stopVal; mPerr = par && badPar;
      end
    end
  endtask

  task automatic readBuf();
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
    @(negedge clk);
    mValid = 0; mOvr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    sendFrame(8, 9'h0A5, 0, 0, 1, 0, -1); checkAll("R2 8-bit");
    readBuf(); checkAll("R11 read clears");
    sendFrame(5, 9'h1F6, 0, 0, 1, 0, -1); checkAll("R2 5-bit masked"); readBuf();
    dataLen = 3'd7;
    sendFrame(9, 9'h13C, 0, 0, 1, 0, -1); checkAll("R7 ninth bit"); readBuf();
    sendFrame(7, 9'h055, 0, 0, 1, 1, -1); checkAll("R12 double speed"); readBuf();
    sendFrame(8, 9'h0C3, 1, 1, 1, 0, -1); checkAll("R5 parity error"); readBuf();
    sendFrame(6, 9'h02A, 1, 0, 1, 1, -1); checkAll("R5 parity good"); readBuf();
    sendFrame(8, 9'h081, 0, 0, 0, 0, -1); checkAll("R6 frame error"); readBuf();
    sendFrame(9, 9'h0F0, 0, 0, 0, 0, -1); checkAll("R6 9-bit frame error"); readBuf();
    sendFrame(8, 9'h0AA, 0, 0, 1, 0, 2);  checkAll("R4 majority glitch"); readBuf();

    // R3: a short low pulse is no start bit
    while (sampleTick !== 1'b1) @(negedge clk);
    holdBit(1'b0, 12);
    holdBit(1'b1, 200);
    checkAll("R3 glitch rejected");

    filterEn = 1'b1;
    sendFrame(9, 9'h042, 0, 0, 1, 0, -1); checkAll("R8 data frame dropped");
    sendFrame(8, 9'h033, 0, 0, 0, 0, -1); checkAll("R8 stop-low dropped");
    sendFrame(8, 9'h017, 0, 0, 1, 0, -1); checkAll("R7 address stored"); readBuf();
    filterEn = 1'b0;
    sendFrame(9, 9'h099, 0, 0, 1, 0, -1); checkAll("R9 data accepted");
    sendFrame(9, 9'h066, 0, 0, 1, 0, -1); checkAll("R10 overrun");
    readBuf(); checkAll("R10 overrun cleared");

    for (int n = 0; n < 40; n++) begin
      int len;
      logic [31:0] r;
      r = $urandom;
      len = 5 + int'(r[2:0] % 5);
      filterEn = (r[5:3] == 3'd0);
      sendFrame(len, 9'($urandom), r[6], r[9:7] == 3'd0, r[12:10] != 3'd0, r[13], -1);
      checkAll("R9 random frame");
      if (r[15:14] != 2'd0) begin readBuf(); checkAll("R11 random read"); end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (190000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule